// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Controller with Holdoff

This block steers a stream of samples into a circular acquisition buffer so that a programmed share of the stored frame lies before a qualifying trigger and the rest lies after it. Software programs five settings: the frame length, the pre-trigger percentage, a post-trigger delay in samples, and a holdoff that either counts trigger events or counts external 100 ns time ticks. The block samples all of these on the cycle that `arm` is high. It then produces the memory write strobe and address for each incoming sample. When the frame is complete it stops writing, raises `done`, and reports the buffer slot of the frame's reference sample.

The sequence starts when a pulse on `arm` moves the machine from IDLE or DONE into PREFILL. If the pre-trigger share is zero, the machine goes to WAIT instead. PREFILL writes the pre-trigger samples, and during PREFILL triggers have no effect. WAIT qualifies triggers against the holdoff. An accepted trigger moves the machine to DELAY when a delay is set. Otherwise it acts at once as the reference sample. DELAY counts the delay samples until the reference sample arrives. POST writes the remaining post-trigger samples. DONE keeps the write strobe low until the next `arm`.

A pulse on `arm` restarts the sequence from any state. The frame can be read out in order starting at slot `trig_addr - pre`, taken modulo the frame length.

Top module: `cap_ctrl`

## Requirements
- R1: During and after reset, `wr_en` and `done` are low, `wr_addr` is 0, and the machine is in IDLE.
- R2: At arm, the frame length is clamped to the range MIN_FRAME to 2^ADDR_W and the percentage is clamped to at most 100. The pre-trigger count is floor(frame*pct/100), and the post-trigger count is the frame length minus the pre-trigger count.
- R3: After an arm, the n-th written sample (counting from 0) is written to address n mod frame length. `wr_en` is only ever high in a cycle where `smp_en` is high.
- R4: While fewer than the pre-trigger count of samples have been written since arm, triggers are ignored and are not counted as holdoff events.
- R5: With `hold_by_time` low and `hold_count` = H, the first H trigger events seen in WAIT are discarded, and the next one is accepted.
- R6: With `hold_by_time` high and `hold_count` = H, a trigger is accepted only after at least H `tick` pulses have been seen in the cycles since arm.
- R7: The reference sample is the sample `post_delay` samples after the accepted trigger, with the delay clamped to MAX_DELAY. `trig_addr` holds the buffer slot of that sample.
- R8: The number of writes after arm is the accepted trigger's sample index, plus the delay, plus the post-trigger count. When the post-trigger count is 0, the reference sample is not written. After the final write, `done` is high and `wr_en` stays low until the next arm.
- R9: A trigger event needs `trig_in` and `smp_en` both high in the same cycle. `trig_in` in a cycle without a sample has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start (or restart) a capture; samples the settings |
| smp_en | input | 1 | A sample is present this cycle |
| trig_in | input | 1 | Trigger qualifier from the comparator |
| tick | input | 1 | 100 ns time-base pulse for time holdoff |
| frame_len | input | ADDR_W+1 | Requested frame length in samples |
| pre_pct | input | 7 | Requested pre-trigger share in percent |
| post_delay | input | DLY_W | Delay in samples from trigger to reference sample |
| hold_by_time | input | 1 | 1: holdoff counts ticks; 0: holdoff counts events |
| hold_count | input | HOLD_W | Holdoff length |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| trig_addr | output | ADDR_W | Buffer slot of the reference sample |
| done | output | 1 | Frame complete |

## Verification
The assertions take for granted that `arm` is the only way to leave DONE and that an `arm` cycle may restart the address. For this reason the address-stepping properties exclude cycles with `arm` high. The assertions make no assumption about the settings inputs, because those are latched at arm. The stimulus raises `arm` only with `smp_en` low, and only after `done` is seen. It keeps `hold_count` and `post_delay` within their ports' widths. While a frame is filling, it drives `trig_in` and `tick` on fixed periodic patterns. This lets the expected acceptance point be worked out sample by sample.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFILL,
        ST_WAIT,
        ST_DELAY,
        ST_POST,
        ST_DONE
    } cap_state_t;
endpackage

// File: rtl/cap_cfg.sv
// Clamps and splits the settings, latching them when arm is seen.
module cap_cfg #(
    parameter int ADDR_W    = 11,
    parameter int MIN_FRAME = 100,
    parameter int DLY_W     = 28,
    parameter int MAX_DELAY = 200_000_000,
    parameter int HOLD_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W:0]   frame_len_i,
    input  logic [6:0]        pre_pct_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic              hold_time_i,
    input  logic [HOLD_W-1:0] hold_val_i,
    output logic [ADDR_W:0]   frame_o,
    output logic [ADDR_W:0]   pre_o,
    output logic [ADDR_W:0]   post_o,
    output logic [DLY_W-1:0]  delay_o,
    output logic              hold_time_o,
    output logic [HOLD_W-1:0] hold_val_o,
    output logic              pre_zero_c
);
    localparam int FW    = ADDR_W + 1;
    localparam int PW    = FW + 7;
    localparam int DEPTH = 1 << ADDR_W;

    logic [FW-1:0]    frame_c;
    logic [6:0]       pct_c;
    logic [PW-1:0]    prod;
    logic [FW-1:0]    pre_c;
    logic [DLY_W-1:0] delay_c;

    always_comb begin
        if (frame_len_i < FW'(MIN_FRAME))
            frame_c = FW'(MIN_FRAME);
        else if (frame_len_i > FW'(DEPTH))
            frame_c = FW'(DEPTH);
        else
            frame_c = frame_len_i;
        pct_c      = (pre_pct_i > 7'd100) ? 7'd100 : pre_pct_i;
        prod       = PW'(frame_c) * PW'(pct_c);
        pre_c      = FW'(prod / PW'(100));
        delay_c    = (delay_i > DLY_W'(MAX_DELAY)) ? DLY_W'(MAX_DELAY) : delay_i;
        pre_zero_c = (pre_c == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o     <= FW'(MIN_FRAME);
            pre_o       <= '0;
            post_o      <= FW'(MIN_FRAME);
            delay_o     <= '0;
            hold_time_o <= 1'b0;
            hold_val_o  <= '0;
        end else if (arm) begin
            frame_o     <= frame_c;
            pre_o       <= pre_c;
            post_o      <= frame_c - pre_c;
            delay_o     <= delay_c;
            hold_time_o <= hold_time_i;
            hold_val_o  <= hold_val_i;
        end
    end
endmodule

// File: rtl/cap_holdoff.sv
// One saturating counter that serves both holdoff modes.
module cap_holdoff #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              active,
    input  logic              in_wait,
    input  logic              smp_en,
    input  logic              trig_in,
    input  logic              tick,
    input  logic              hold_time,
    input  logic [HOLD_W-1:0] hold_val,
    output logic              hold_clear
);
    logic [HOLD_W-1:0] cnt;
    logic              inc;

    always_comb begin
        inc        = hold_time ? (tick && active) : (in_wait && smp_en && trig_in);
        hold_clear = (cnt == hold_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || arm)
            cnt <= '0;
        else if (inc && (cnt < hold_val))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cap_seq.sv
// Fill sequencer: state machine, write address, sample counter, reference slot.
module cap_seq
    import cap_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DLY_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              smp_en,
    input  logic              trig_in,
    input  logic              hold_clear,
    input  logic              pre_zero_c,
    input  logic [ADDR_W:0]   frame,
    input  logic [ADDR_W:0]   pre,
    input  logic [ADDR_W:0]   post,
    input  logic [DLY_W-1:0]  delay,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] trig_addr,
    output logic              done,
    output logic              active,
    output logic              in_wait
);
    localparam int FW = ADDR_W + 1;
    localparam int CW = (DLY_W > FW) ? DLY_W : FW;

    cap_state_t        state, nxt;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cnt_inc;
    logic              accept, ref_hit, short_post;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and outputs
    always_comb begin
        cnt_inc    = cnt + 1'b1;
        short_post = (post <= FW'(1));
        accept     = (state == ST_WAIT) && smp_en && trig_in && hold_clear;
        ref_hit    = (accept && (delay == '0)) ||
                     ((state == ST_DELAY) && smp_en && (cnt_inc == CW'(delay)));
        active     = (state != ST_IDLE) && (state != ST_DONE);
        in_wait    = (state == ST_WAIT);
        done       = (state == ST_DONE);
        wr_en      = smp_en && active && !(ref_hit && (post == '0));
        nxt        = state;
        unique case (state)
            ST_IDLE, ST_DONE: nxt = state;
            ST_PREFILL: if (smp_en && (cnt_inc == CW'(pre))) nxt = ST_WAIT;
            ST_WAIT: begin
                if (accept) begin
                    if (delay != '0)     nxt = ST_DELAY;
                    else if (short_post) nxt = ST_DONE;
                    else                 nxt = ST_POST;
                end
            end
            ST_DELAY: if (ref_hit) nxt = short_post ? ST_DONE : ST_POST;
            ST_POST:  if (smp_en && (cnt_inc == CW'(post))) nxt = ST_DONE;
            default:  nxt = ST_IDLE;
        endcase
        if (arm) nxt = pre_zero_c ? ST_WAIT : ST_PREFILL;
    end

    // Address, sample counter and reference slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr   <= '0;
            cnt       <= '0;
            trig_addr <= '0;
        end else if (arm) begin
            wr_addr <= '0;
            cnt     <= '0;
        end else begin
            if (wr_en)
                wr_addr <= ({1'b0, wr_addr} == frame - 1'b1) ? '0 : wr_addr + 1'b1;
            if (ref_hit)
                trig_addr <= wr_addr;
            unique case (state)
                ST_PREFILL: if (smp_en) cnt <= cnt_inc;
                ST_WAIT:    if (accept) cnt <= (delay == '0) ? CW'(1) : '0;
                ST_DELAY:   if (smp_en) cnt <= ref_hit ? CW'(1) : cnt_inc;
                ST_POST:    if (smp_en) cnt <= cnt_inc;
                default:    cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl #(
    parameter int ADDR_W    = 11,
    parameter int MIN_FRAME = 100,
    parameter int DLY_W     = 28,
    parameter int MAX_DELAY = 200_000_000,
    parameter int HOLD_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              smp_en,
    input  logic              trig_in,
    input  logic              tick,
    input  logic [ADDR_W:0]   frame_len,
    input  logic [6:0]        pre_pct,
    input  logic [DLY_W-1:0]  post_delay,
    input  logic              hold_by_time,
    input  logic [HOLD_W-1:0] hold_count,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] trig_addr,
    output logic              done
);
    logic [ADDR_W:0]   frame_q, pre_q, post_q;
    logic [DLY_W-1:0]  delay_q;
    logic              hold_time_q, pre_zero_c, hold_clear, active, in_wait;
    logic [HOLD_W-1:0] hold_val_q;

    cap_cfg #(
        .ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME), .DLY_W(DLY_W),
        .MAX_DELAY(MAX_DELAY), .HOLD_W(HOLD_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .arm(arm),
        .frame_len_i(frame_len), .pre_pct_i(pre_pct), .delay_i(post_delay),
        .hold_time_i(hold_by_time), .hold_val_i(hold_count),
        .frame_o(frame_q), .pre_o(pre_q), .post_o(post_q), .delay_o(delay_q),
        .hold_time_o(hold_time_q), .hold_val_o(hold_val_q), .pre_zero_c(pre_zero_c)
    );

    cap_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .arm(arm), .active(active), .in_wait(in_wait),
        .smp_en(smp_en), .trig_in(trig_in), .tick(tick),
        .hold_time(hold_time_q), .hold_val(hold_val_q), .hold_clear(hold_clear)
    );

    cap_seq #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .trig_in(trig_in),
        .hold_clear(hold_clear), .pre_zero_c(pre_zero_c),
        .frame(frame_q), .pre(pre_q), .post(post_q), .delay(delay_q),
        .wr_en(wr_en), .wr_addr(wr_addr), .trig_addr(trig_addr), .done(done),
        .active(active), .in_wait(in_wait)
    );
endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              smp_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] trig_addr,
    input logic              done
);
    p_write_needs_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> smp_en);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !arm) |=> (wr_addr == $past(wr_addr) + 1'b1) || (wr_addr == '0));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !arm) |=> $stable(wr_addr));

    p_done_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    p_ref_slot_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> $stable(trig_addr));

    p_arm_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!done && (wr_addr == '0)));
endmodule

bind cap_ctrl cap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .trig_addr(trig_addr), .done(done)
);

// File: tb/cap_ctrl_test.sv
module cap_ctrl_test;
    localparam int CLK_P     = 10;
    localparam int ADDR_W    = 6;
    localparam int MIN_FRAME = 8;
    localparam int DLY_W     = 8;
    localparam int MAX_DELAY = 20;
    localparam int HOLD_W    = 4;
    localparam int DEPTH     = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm = 1'b0, smp_en = 1'b0, trig_in = 1'b0, tick = 1'b0;
    logic [ADDR_W:0]   frame_len = '0;
    logic [6:0]        pre_pct = '0;
    logic [DLY_W-1:0]  post_delay = '0;
    logic              hold_by_time = 1'b0;
    logic [HOLD_W-1:0] hold_count = '0;
    logic              wr_en, done;
    logic [ADDR_W-1:0] wr_addr, trig_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;

    always #(CLK_P/2) clk = ~clk;

    cap_ctrl #(
        .ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME), .DLY_W(DLY_W),
        .MAX_DELAY(MAX_DELAY), .HOLD_W(HOLD_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .trig_in(trig_in),
        .tick(tick), .frame_len(frame_len), .pre_pct(pre_pct),
        .post_delay(post_delay), .hold_by_time(hold_by_time),
        .hold_count(hold_count), .wr_en(wr_en), .wr_addr(wr_addr),
        .trig_addr(trig_addr), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total == 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run_one(input int fl, input int pp, input int dl,
                           input bit ht, input int hv, input int t0, input bit gap);
        int fc, pc, pre, post, d, k, nw, acc, ign, ticks, e, cyc;
        bit accd, se, tg, tk, hok, exp_we;
        string lbl;
        fc   = (fl < MIN_FRAME) ? MIN_FRAME : ((fl > DEPTH) ? DEPTH : fl);
        pc   = (pp > 100) ? 100 : pp;
        pre  = fc * pc / 100;
        post = fc - pre;
        d    = (dl > MAX_DELAY) ? MAX_DELAY : dl;
        @(negedge clk);
        frame_len = fl[ADDR_W:0]; pre_pct = pp[6:0]; post_delay = dl[DLY_W-1:0];
        hold_by_time = ht; hold_count = hv[HOLD_W-1:0];
        arm = 1'b1; smp_en = 1'b0; trig_in = 1'b0; tick = 1'b0;
        k = 0; nw = 0; acc = 0; ign = 0; ticks = 0; e = 0; cyc = 0; accd = 1'b0;
        forever begin
            cyc++;
            @(negedge clk);
            arm = 1'b0;
            se  = gap ? ((cyc % 5) != 4) : 1'b1;
            tg  = ((cyc + t0) % 3) == 0;
            tk  = (cyc % 3) == 2;
            smp_en = se; trig_in = tg; tick = tk;
            #1;
            if (se) begin
                if (tg && !accd && k >= pre) begin
                    hok = ht ? (ticks >= hv) : (ign >= hv);
                    if (hok) begin
                        accd = 1'b1; acc = k; e = acc + d + post;
                    end else if (!ht) ign++;
                end
                k++;
            end
            exp_we = se && (!accd || nw < e);
            if (!accd) lbl = ht ? "R6" : ((hv > 0) ? "R5" : "R4");
            else       lbl = "R8";
            chk(wr_en == exp_we, lbl, int'(wr_en), int'(exp_we));
            if (wr_en && exp_we)
                chk(int'(wr_addr) == nw % fc, (fc != fl) ? "R2" : "R3",
                    int'(wr_addr), nw % fc);
            if (exp_we) nw++;
            if (tk) ticks++;
            if (accd && nw == e && k >= acc + d + 1) break;
            if (cyc > 4000) begin
                chk(1'b0, "R8", cyc, 0);
                break;
            end
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_en = 1'b1; trig_in = 1'b1; tick = 1'b0;
            #1;
            chk(done == 1'b1, "R8", int'(done), 1);
            chk(wr_en == 1'b0, "R8", int'(wr_en), 0);
        end
        chk(int'(trig_addr) == (acc + d) % fc, gap ? "R9" : "R7",
            int'(trig_addr), (acc + d) % fc);
        @(negedge clk);
        smp_en = 1'b0; trig_in = 1'b0;
    endtask

    initial begin
        int fls[6]  = '{0, 5, 8, 13, 64, 100};
        int pps[6]  = '{0, 25, 50, 99, 100, 127};
        int dls[4]  = '{0, 1, 3, 50};
        int run;
        run = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(wr_en == 1'b0, "R1", int'(wr_en), 0);
        chk(done == 1'b0, "R1", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        smp_en = 1'b1; trig_in = 1'b1; tick = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(wr_en == 1'b0, "R1", int'(wr_en), 0);
        chk(done == 1'b0, "R1", int'(done), 0);
        chk(wr_addr == '0, "R1", int'(wr_addr), 0);
        smp_en = 1'b0; trig_in = 1'b0; tick = 1'b0;
        for (int f = 0; f < 6; f++)
            for (int p = 0; p < 6; p++)
                for (int dd = 0; dd < 4; dd++)
                    for (int h = 0; h < 3; h++) begin
                        run_one(fls[f], pps[p], dls[dd], h == 2,
                                (h == 0) ? 0 : ((h == 1) ? 2 : 3), run % 3, run[0]);
                        run++;
                    end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule